// File: doc/BRIEF.md
# Hardwired Control Step Sequencer

This block is the control unit of a single-bus 32-bit processor. It keeps a small step counter and, from the current step and the opcode held in the instruction register, it drives the gate signals that put one value on the shared bus and the strobe signals that capture it. Fetch takes three steps and is the same for every instruction. After fetch the block runs the execution steps of register add, immediate add, load and store, and then returns to the first fetch step.

Steps that touch memory stall until the memory reports completion. A soft reset request, sampled on the clock, spends one cycle clearing the program counter and then restarts fetch, whatever step or opcode is current. Opcodes the block does not know end the sequence directly after fetch. Every output is a combinational decode of registered state and the opcode, so a control signal is valid for the whole step it belongs to.

Top module: `step_sequencer`

## Requirements
- R1: After hard reset or End, step 0 drives pcToBus, maLoad, incFour, cLoad and memRead and no other control, and the counter moves to step 1 on the next edge whatever memDone is.
- R2: Step 1 drives cToBus and pcLoad. The counter stays in step 1 on every edge where memDone is low and moves to step 2 on the first edge where memDone is high.
- R3: Step 2 drives mdToBus and irLoad only.
- R4: With opcode 12 (register add), step 3 drives selRb, regToBus and aLoad; step 4 drives selRc, regToBus, aluAdd and cLoad; step 5 drives cToBus, selRa, regLoad and seqEnd.
- R5: With opcode 13 (immediate add), steps 3 and 5 match R4 and step 4 drives constToBus, aluAdd and cLoad.
- R6: With opcode 1 (load) or 3 (store), step 3 drives selRb, baseToBus and aLoad; step 4 drives constToBus, aluAdd and cLoad; step 5 drives cToBus and maLoad.
- R7: With opcode 1, step 6 drives memRead and waits on memDone as in R2; step 7 drives mdToBus, selRa, regLoad and seqEnd.
- R8: With opcode 3, step 6 drives selRa, regToBus, mdLoad and memWrite; step 7 drives seqEnd and waits on memDone, leaving for step 0 only on an edge with memDone high.
- R9: In a step that drives seqEnd and is not waiting, the next edge returns the counter to step 0.
- R10: A high softRst at an edge makes the following cycle drive pcClear and no other control; the edge after that cycle puts the counter in step 0, also when it was stalled on memory.
- R11: Any opcode other than 1, 3, 12 and 13 makes step 3 drive seqEnd only, so fetch restarts at the next edge.
- R12: While rstN is low the counter is held at step 0 and the soft reset request is cleared.
- R13: Bit i of stepOh is high exactly when the counter is in step i (outside the pcClear cycle).
- R14: In every cycle at most one of pcToBus, cToBus, mdToBus, regToBus, baseToBus and constToBus is high, and memRead and memWrite are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hard reset, active low |
| softRst | input | 1 | Soft reset request, sampled on the clock |
| opcode | input | 5 | Opcode field of the instruction register |
| memDone | input | 1 | Memory completion |
| pcToBus | output | 1 | Gate PC onto the bus |
| maLoad | output | 1 | Strobe memory address register |
| incFour | output | 1 | ALU adds four to the bus value |
| cLoad | output | 1 | Strobe ALU result register |
| memRead | output | 1 | Start a memory read |
| memWrite | output | 1 | Start a memory write |
| cToBus | output | 1 | Gate ALU result register onto the bus |
| pcLoad | output | 1 | Strobe PC |
| mdToBus | output | 1 | Gate memory data register onto the bus |
| mdLoad | output | 1 | Strobe memory data register from the bus |
| irLoad | output | 1 | Strobe instruction register |
| selRa | output | 1 | Select destination register field |
| selRb | output | 1 | Select base/first source field |
| selRc | output | 1 | Select second source field |
| regToBus | output | 1 | Gate selected register onto the bus |
| baseToBus | output | 1 | Gate selected register, or zero for register 0, onto the bus |
| regLoad | output | 1 | Strobe selected register |
| aLoad | output | 1 | Strobe ALU operand register |
| constToBus | output | 1 | Gate sign-extended constant onto the bus |
| aluAdd | output | 1 | ALU adds operand register and bus |
| seqEnd | output | 1 | Last step of the instruction |
| pcClear | output | 1 | Clear PC during soft reset |
| stepOh | output | 8 | One-hot current step |

## Verification
The hardest states to reach are the memory stalls that overlap other events: a soft reset arriving while step 1 is waiting, and the store's final step, where seqEnd is already high but the counter must not leave until memDone rises. The stimulus holds memDone low for a chosen number of cycles in each waiting step, checking that the control set and step indicator stay frozen, and raises softRst in the middle of a stall and in the middle of an add to see the single clear cycle and the restart at step 0.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef struct packed {
    logic pcToBus;
    logic maLoad;
    logic incFour;
    logic cLoad;
    logic memRead;
    logic memWrite;
    logic cToBus;
    logic pcLoad;
    logic mdToBus;
    logic mdLoad;
    logic irLoad;
    logic selRa;
    logic selRb;
    logic selRc;
    logic regToBus;
    logic baseToBus;
    logic regLoad;
    logic aLoad;
    logic constToBus;
    logic aluAdd;
    logic seqEnd;
    logic pcClear;
  } ctl_t;

  typedef struct packed {
    logic holdForMem;
    logic endNow;
    logic flush;
  } stepReq_t;

endpackage

// File: rtl/seq_step_counter.sv
module seq_step_counter
  import seq_pkg::*;
#(
  parameter int STEP_W = 3,
  localparam int NUM_STEPS = 1 << STEP_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stepReq_t             req,
  input  logic                 memDone,
  output logic [STEP_W-1:0]    stepQ,
  output logic [NUM_STEPS-1:0] stepOh
);

  logic [STEP_W-1:0] stepD;
  logic              stall;

  assign stall = req.holdForMem && !memDone;

  always_comb begin
    if (req.flush)       stepD = '0;
    else if (stall)      stepD = stepQ;
    else if (req.endNow) stepD = '0;
    else                 stepD = stepQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepQ <= '0;
    else       stepQ <= stepD;
  end

  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_stepDecode
    assign stepOh[i] = (stepQ == STEP_W'(i));
  end

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (req.holdForMem && !memDone && !req.flush) |=> (stepQ == $past(stepQ))); // R2

  AST_END_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (req.endNow && !stall) |=> (stepQ == '0)); // R9

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (!req.flush && !req.endNow && !stall) |=> (stepQ == $past(stepQ) + 1'b1)); // R1

endmodule

// File: rtl/seq_soft_reset_flag.sv
module seq_soft_reset_flag (
  input  logic clk,
  input  logic rstN,
  input  logic softRst,
  output logic flagQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= 1'b0;
    else       flagQ <= softRst;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> flagQ); // R10

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !softRst) |=> !flagQ); // R10

endmodule

// File: rtl/seq_step_decode.sv
module seq_step_decode
  import seq_pkg::*;
#(
  parameter int OPC_W   = 5,
  parameter int OP_LD   = 1,
  parameter int OP_ST   = 3,
  parameter int OP_ADD  = 12,
  parameter int OP_ADDI = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       stepOh,
  input  logic [OPC_W-1:0] opcode,
  input  logic             softFlag,
  output ctl_t             ctl,
  output stepReq_t         req
);

  logic isAdd, isAddi, isLd, isSt, isArith, isMem, isKnown;

  assign isAdd   = (opcode == OPC_W'(OP_ADD));
  assign isAddi  = (opcode == OPC_W'(OP_ADDI));
  assign isLd    = (opcode == OPC_W'(OP_LD));
  assign isSt    = (opcode == OPC_W'(OP_ST));
  assign isArith = isAdd || isAddi;
  assign isMem   = isLd || isSt;
  assign isKnown = isArith || isMem;

  always_comb begin
    ctl = '0;
    req = '0;
    if (softFlag) begin
      ctl.pcClear = 1'b1;
      req.flush   = 1'b1;
    end else begin
      if (stepOh[0]) begin
        ctl.pcToBus = 1'b1;
        ctl.maLoad  = 1'b1;
        ctl.incFour = 1'b1;
        ctl.cLoad   = 1'b1;
        ctl.memRead = 1'b1;
      end
      if (stepOh[1]) begin
        ctl.cToBus     = 1'b1;
        ctl.pcLoad     = 1'b1;
        req.holdForMem = 1'b1;
      end
      if (stepOh[2]) begin
        ctl.mdToBus = 1'b1;
        ctl.irLoad  = 1'b1;
      end
      if (stepOh[3]) begin
        if (isArith) begin
          ctl.selRb    = 1'b1;
          ctl.regToBus = 1'b1;
          ctl.aLoad    = 1'b1;
        end else if (isMem) begin
          ctl.selRb     = 1'b1;
          ctl.baseToBus = 1'b1;
          ctl.aLoad     = 1'b1;
        end else begin
          ctl.seqEnd = 1'b1;
          req.endNow = 1'b1;
        end
      end
      if (stepOh[4]) begin
        if (isAdd) begin
          ctl.selRc    = 1'b1;
          ctl.regToBus = 1'b1;
          ctl.aluAdd   = 1'b1;
          ctl.cLoad    = 1'b1;
        end else if (isAddi || isMem) begin
          ctl.constToBus = 1'b1;
          ctl.aluAdd     = 1'b1;
          ctl.cLoad      = 1'b1;
        end
      end
      if (stepOh[5]) begin
        if (isArith) begin
          ctl.cToBus  = 1'b1;
          ctl.selRa   = 1'b1;
          ctl.regLoad = 1'b1;
          ctl.seqEnd  = 1'b1;
          req.endNow  = 1'b1;
        end else if (isMem) begin
          ctl.cToBus = 1'b1;
          ctl.maLoad = 1'b1;
        end
      end
      if (stepOh[6]) begin
        if (isSt) begin
          ctl.selRa    = 1'b1;
          ctl.regToBus = 1'b1;
          ctl.mdLoad   = 1'b1;
          ctl.memWrite = 1'b1;
        end else if (isLd) begin
          ctl.memRead    = 1'b1;
          req.holdForMem = 1'b1;
        end
      end
      if (stepOh[7]) begin
        if (isSt) begin
          req.holdForMem = 1'b1;
          ctl.seqEnd     = 1'b1;
          req.endNow     = 1'b1;
        end else if (isLd) begin
          ctl.mdToBus = 1'b1;
          ctl.selRa   = 1'b1;
          ctl.regLoad = 1'b1;
          ctl.seqEnd  = 1'b1;
          req.endNow  = 1'b1;
        end
      end
      if (!isKnown && (stepOh[7:4] != 4'b0000)) begin
        req.endNow = 1'b1;
      end
    end
  end

  AST_ONE_BUS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.pcToBus, ctl.cToBus, ctl.mdToBus, ctl.regToBus,
              ctl.baseToBus, ctl.constToBus})); // R14

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.memRead && ctl.memWrite)); // R14

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
  import seq_pkg::*;
#(
  parameter int STEP_W  = 3,
  parameter int OPC_W   = 5,
  parameter int OP_LD   = 1,
  parameter int OP_ST   = 3,
  parameter int OP_ADD  = 12,
  parameter int OP_ADDI = 13,
  localparam int NUM_STEPS = 1 << STEP_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 softRst,
  input  logic [OPC_W-1:0]     opcode,
  input  logic                 memDone,
  output logic                 pcToBus,
  output logic                 maLoad,
  output logic                 incFour,
  output logic                 cLoad,
  output logic                 memRead,
  output logic                 memWrite,
  output logic                 cToBus,
  output logic                 pcLoad,
  output logic                 mdToBus,
  output logic                 mdLoad,
  output logic                 irLoad,
  output logic                 selRa,
  output logic                 selRb,
  output logic                 selRc,
  output logic                 regToBus,
  output logic                 baseToBus,
  output logic                 regLoad,
  output logic                 aLoad,
  output logic                 constToBus,
  output logic                 aluAdd,
  output logic                 seqEnd,
  output logic                 pcClear,
  output logic [NUM_STEPS-1:0] stepOh
);

  ctl_t              ctl;
  stepReq_t          req;
  logic              softFlag;
  logic [STEP_W-1:0] stepQ;

  seq_soft_reset_flag u_flag (
    .clk     (clk),
    .rstN    (rstN),
    .softRst (softRst),
    .flagQ   (softFlag)
  );

  seq_step_counter #(.STEP_W(STEP_W)) u_counter (
    .clk     (clk),
    .rstN    (rstN),
    .req     (req),
    .memDone (memDone),
    .stepQ   (stepQ),
    .stepOh  (stepOh)
  );

  seq_step_decode #(
    .OPC_W   (OPC_W),
    .OP_LD   (OP_LD),
    .OP_ST   (OP_ST),
    .OP_ADD  (OP_ADD),
    .OP_ADDI (OP_ADDI)
  ) u_decode (
    .clk      (clk),
    .rstN     (rstN),
    .stepOh   (stepOh[7:0]),
    .opcode   (opcode),
    .softFlag (softFlag),
    .ctl      (ctl),
    .req      (req)
  );

  assign pcToBus    = ctl.pcToBus;
  assign maLoad     = ctl.maLoad;
  assign incFour    = ctl.incFour;
  assign cLoad      = ctl.cLoad;
  assign memRead    = ctl.memRead;
  assign memWrite   = ctl.memWrite;
  assign cToBus     = ctl.cToBus;
  assign pcLoad     = ctl.pcLoad;
  assign mdToBus    = ctl.mdToBus;
  assign mdLoad     = ctl.mdLoad;
  assign irLoad     = ctl.irLoad;
  assign selRa      = ctl.selRa;
  assign selRb      = ctl.selRb;
  assign selRc      = ctl.selRc;
  assign regToBus   = ctl.regToBus;
  assign baseToBus  = ctl.baseToBus;
  assign regLoad    = ctl.regLoad;
  assign aLoad      = ctl.aLoad;
  assign constToBus = ctl.constToBus;
  assign aluAdd     = ctl.aluAdd;
  assign seqEnd     = ctl.seqEnd;
  assign pcClear    = ctl.pcClear;

  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (pcClear && !softRst) |=> (stepOh[0] && !pcClear)); // R10

  AST_STEP_IDLE_RESET: assert property (@(posedge clk)
    !rstN |-> stepOh[0]); // R12

endmodule

// File: tb/sim_step_sequencer.sv
`timescale 1ns/1ps
module sim_step_sequencer;

  localparam int OP_LD = 1, OP_ST = 3, OP_ADD = 12, OP_ADDI = 13, OP_BAD = 7;

  localparam int B_PCB = 21, B_MAL = 20, B_INC = 19, B_CL = 18, B_RD = 17,
                 B_WR = 16, B_CB = 15, B_PCL = 14, B_MDB = 13, B_MDL = 12,
                 B_IRL = 11, B_SRA = 10, B_SRB = 9, B_SRC = 8, B_RB = 7,
                 B_BAB = 6, B_RL = 5, B_AL = 4, B_KB = 3, B_ADD = 2,
                 B_END = 1, B_CLR = 0;

  logic clk = 0, rstN = 0, softRst = 0, memDone = 0;
  logic [4:0] opcode = 0;
  logic pcToBus, maLoad, incFour, cLoad, memRead, memWrite, cToBus, pcLoad,
        mdToBus, mdLoad, irLoad, selRa, selRb, selRc, regToBus, baseToBus,
        regLoad, aLoad, constToBus, aluAdd, seqEnd, pcClear;
  logic [7:0] stepOh;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  step_sequencer u0 (
    .clk(clk), .rstN(rstN), .softRst(softRst), .opcode(opcode), .memDone(memDone),
    .pcToBus(pcToBus), .maLoad(maLoad), .incFour(incFour), .cLoad(cLoad),
    .memRead(memRead), .memWrite(memWrite), .cToBus(cToBus), .pcLoad(pcLoad),
    .mdToBus(mdToBus), .mdLoad(mdLoad), .irLoad(irLoad), .selRa(selRa),
    .selRb(selRb), .selRc(selRc), .regToBus(regToBus), .baseToBus(baseToBus),
    .regLoad(regLoad), .aLoad(aLoad), .constToBus(constToBus), .aluAdd(aluAdd),
    .seqEnd(seqEnd), .pcClear(pcClear), .stepOh(stepOh)
  );

  function automatic logic [21:0] actVec();
    return {pcToBus, maLoad, incFour, cLoad, memRead, memWrite, cToBus, pcLoad,
            mdToBus, mdLoad, irLoad, selRa, selRb, selRc, regToBus, baseToBus,
            regLoad, aLoad, constToBus, aluAdd, seqEnd, pcClear};
  endfunction

  function automatic logic [21:0] expVec(int s, int opc);
    logic [21:0] v = '0;
    bit arith = (opc == OP_ADD) || (opc == OP_ADDI);
    bit mem   = (opc == OP_LD) || (opc == OP_ST);
    case (s)
      0: begin v[B_PCB]=1; v[B_MAL]=1; v[B_INC]=1; v[B_CL]=1; v[B_RD]=1; end
      1: begin v[B_CB]=1; v[B_PCL]=1; end
      2: begin v[B_MDB]=1; v[B_IRL]=1; end
      3: if (arith) begin v[B_SRB]=1; v[B_RB]=1; v[B_AL]=1; end
         else if (mem) begin v[B_SRB]=1; v[B_BAB]=1; v[B_AL]=1; end
         else v[B_END]=1;
      4: if (opc == OP_ADD) begin v[B_SRC]=1; v[B_RB]=1; v[B_ADD]=1; v[B_CL]=1; end
         else begin v[B_KB]=1; v[B_ADD]=1; v[B_CL]=1; end
      5: if (arith) begin v[B_CB]=1; v[B_SRA]=1; v[B_RL]=1; v[B_END]=1; end
         else begin v[B_CB]=1; v[B_MAL]=1; end
      6: if (opc == OP_ST) begin v[B_SRA]=1; v[B_RB]=1; v[B_MDL]=1; v[B_WR]=1; end
         else v[B_RD]=1;
      default: if (opc == OP_ST) v[B_END]=1;
               else begin v[B_MDB]=1; v[B_SRA]=1; v[B_RL]=1; v[B_END]=1; end
    endcase
    return v;
  endfunction

  function automatic string reqTag(int s, int opc);
    if (s == 0) return "R1";
    if (s == 1) return "R2";
    if (s == 2) return "R3";
    if (opc == OP_ADD) return "R4";
    if (opc == OP_ADDI) return "R5";
    if (s <= 5 && (opc == OP_LD || opc == OP_ST)) return "R6";
    if (opc == OP_LD) return "R7";
    if (opc == OP_ST) return "R8";
    return "R11";
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkBus(); // R14
    checks++;
    if (!$onehot0({pcToBus, cToBus, mdToBus, regToBus, baseToBus, constToBus}) ||
        (memRead && memWrite)) begin
      failures++;
      $display("FAIL R14 actual=%h expected=onehot0 gates time=%0t", actVec(), $time);
    end
  endtask

  task automatic checkStep(int s, int opc);
    string t = reqTag(s, opc);
    checkVal(t, 32'(actVec()), 32'(expVec(s, opc)));
    checkVal("R13", 32'(stepOh), 32'(1 << s));
    checkBus();
  endtask

  task automatic runInstr(int opc, int delay);
    int n;
    opcode = 5'(opc);
    n = (opc == OP_ADD || opc == OP_ADDI) ? 6 : ((opc == OP_LD || opc == OP_ST) ? 8 : 4);
    for (int s = 0; s < n; s++) begin
      bit w = (s == 1) || (opc == OP_LD && s == 6) || (opc == OP_ST && s == 7);
      if (w) begin
        for (int d = 0; d < delay; d++) begin
          memDone = 0;
          checkStep(s, opc);
          tick();
        end
        memDone = 1;
      end else begin
        memDone = (s == 0);
      end
      checkStep(s, opc);
      tick();
      memDone = 0;
    end
    checkVal("R9", 32'(stepOh), 32'h1);
    checkVal("R9", 32'(actVec()), 32'(expVec(0, opc)));
  endtask

  task automatic testHardReset();
    rstN = 0;
    opcode = 5'(OP_ADD);
    memDone = 1;
    repeat (3) tick();
    checkVal("R12", 32'(stepOh), 32'h1);
    checkVal("R12", 32'(actVec()), 32'(expVec(0, OP_ADD)));
    memDone = 0;
    rstN = 1;
    tick();
    checkVal("R1", 32'(stepOh), 32'h2);
    checkVal("R2", 32'(actVec()), 32'(expVec(1, OP_ADD)));
    memDone = 1;
    tick();
    memDone = 0;
    checkVal("R2", 32'(stepOh), 32'h4);
    tick();
    tick();
    tick();
    tick();
    checkVal("R9", 32'(stepOh), 32'h1);
  endtask

  task automatic testSoftMidAdd();
    opcode = 5'(OP_ADD);
    memDone = 1;
    for (int s = 0; s < 4; s++) tick();
    memDone = 0;
    checkVal("R4", 32'(stepOh), 32'h10);
    softRst = 1;
    tick();
    softRst = 0;
    checkVal("R10", 32'(actVec()), 32'(1 << B_CLR));
    tick();
    checkVal("R10", 32'(stepOh), 32'h1);
    checkVal("R10", 32'(actVec()), 32'(expVec(0, OP_ADD)));
  endtask

  task automatic testSoftInStall();
    opcode = 5'(OP_ST);
    memDone = 0;
    tick();
    tick();
    checkVal("R2", 32'(stepOh), 32'h2);
    softRst = 1;
    tick();
    softRst = 0;
    checkVal("R10", 32'(actVec()), 32'(1 << B_CLR));
    tick();
    checkVal("R10", 32'(stepOh), 32'h1);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    testHardReset();
    runInstr(OP_ADD, 0);
    runInstr(OP_ADD, 3);
    runInstr(OP_ADDI, 1);
    runInstr(OP_LD, 2);
    runInstr(OP_ST, 3);
    runInstr(OP_ST, 0);
    runInstr(OP_BAD, 1);
    runInstr(0, 0);
    testSoftMidAdd();
    runInstr(OP_ADD, 1);
    testSoftInStall();
    runInstr(OP_LD, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule